// File: doc/BRIEF.md
# PS/2 Keyboard Frame Receiver

This block turns the serial stream that a PS/2 keyboard drives on its clock and data wires into whole bytes for the system side. The two keyboard lines are brought into the system clock domain through flop synchronizers. A falling edge on the synchronized keyboard clock is then found, and the data line is sampled there. A four-step sequencer walks through the start bit, the data bits, the parity bit and the stop bit of each 11-bit frame.

A frame that ends cleanly presents its byte on `rx_byte` together with a single-cycle `rx_valid` strobe. A frame whose parity does not match raises a one-cycle `parity_err` pulse, which a companion transmitter can use to ask the keyboard to send the frame again (command byte 0xFE). An inactivity timer, sized in microseconds from the system clock frequency, drops a half-received frame when the keyboard clock stops. Every following frame then starts from a clean state.

Top module: `ps2_frame_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rx_valid` and `parity_err` are 0 and `rx_byte` is 0x00.
- R2: A frame made of a 0 start bit, 8 data bits sent least significant first, a correct parity bit and a 1 stop bit produces exactly one `rx_valid` cycle. In that cycle `rx_byte` holds the data with the first data bit in bit 0.
- R3: The parity bit is correct when it is 1 for a data byte with an even number of ones and 0 for an odd number. A wrong parity bit gives exactly one `parity_err` cycle, gives no `rx_valid`, and returns the receiver to waiting for a start bit.
- R4: A keyboard clock falling edge that samples data high while the receiver waits for a start bit is ignored. It gives no strobe, and the next proper frame is received intact.
- R5: A frame whose stop bit samples low is discarded. It gives neither `rx_valid` nor `parity_err`, and the next proper frame is received intact.
- R6: If no keyboard clock falling edge occurs for TIMEOUT_US microseconds of system clock, a partly received frame is abandoned and the receiver waits for a start bit again. A gap shorter than that between bits leaves the frame intact.
- R7: `rx_byte` changes only in a cycle where `rx_valid` is 1. Rejected frames leave it unchanged.
- R8: `rx_valid` and `parity_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ps2_clk_in | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_in | input | 1 | Keyboard data line, asynchronous |
| rx_byte | output | DATA_W | Last correctly received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte |
| parity_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
The main path is driven with all-zero, all-one, alternating, single-bit and mixed bytes, so that bit order, the parity polarity for even and odd counts of ones, and both end bits are each told apart. Corrupted frames are sent with a high start bit, a low stop bit or an inverted parity bit. After each corrupted frame, the bench checks which pulse appears and whether the held byte survives. Two frames with a stall in the middle are also sent: one whose gap is longer than the timeout and one whose gap is well inside it. These show that the timer clears a half-received frame and does not cut a slow but live frame short.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_PAR  = 2'd2,
      ST_STOP = 2'd3
   } rx_step_t;

   // expected parity bit: high when the data word holds an even count of ones
   function automatic logic odd_par_bit(input logic [63:0] word, input int unsigned width);
      logic acc;
      acc = 1'b1;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < width) acc = acc ^ word[i];
      end
      return acc;
   endfunction

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
   parameter int unsigned STAGES   = 2,
   parameter logic        RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ps2rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/ps2rx_fall_det.sv
module ps2rx_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic fall
);

   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b1;
      else        level_q <= level_in;
   end

   assign fall = level_q & ~level_in;

   // a falling edge needs a high sample before it, so two in a row cannot occur
   assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);

endmodule

// File: rtl/ps2rx_idle_timer.sv
module ps2rx_idle_timer #(
   parameter int unsigned LIMIT = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("ps2rx_idle_timer: LIMIT must be at least 2");
      end
   endgenerate

   localparam int unsigned TW = $clog2(LIMIT + 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt <= '0;
      else if (restart)          cnt <= '0;
      else if (cnt != TW'(LIMIT)) cnt <= cnt + 1'b1;
   end

   assign expired = (cnt == TW'(LIMIT));

   // once expired, the timer stays expired until a bit restarts it
   assert_expired_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !restart) |=> expired);

   // a restart always clears the expiry in the next cycle
   assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expired);

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
   import ps2rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLK_FREQ_HZ = 50_000_000,
   parameter int unsigned TIMEOUT_US  = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ps2_clk_in,
   input  logic              ps2_dat_in,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_valid,
   output logic              parity_err
);

   localparam int unsigned TICKS_PER_US = CLK_FREQ_HZ / 1_000_000;
   localparam int unsigned TO_CYCLES    = TICKS_PER_US * TIMEOUT_US;
   localparam int unsigned CNT_W        = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2 || DATA_W > 64) begin : g_bad_width
         $error("ps2_frame_rx: DATA_W must be within 2..64");
      end
      if (TICKS_PER_US == 0) begin : g_bad_freq
         $error("ps2_frame_rx: CLK_FREQ_HZ must be at least 1 MHz");
      end
   endgenerate

   // line conditioning
   logic kclk_s, kdat_s, kfall, idle_to;

   ps2rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_in(ps2_clk_in), .sync_out(kclk_s));

   ps2rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_dat (
      .clk(clk), .rst_n(rst_n), .async_in(ps2_dat_in), .sync_out(kdat_s));

   ps2rx_fall_det i_fall (
      .clk(clk), .rst_n(rst_n), .level_in(kclk_s), .fall(kfall));

   ps2rx_idle_timer #(.LIMIT(TO_CYCLES)) i_timer (
      .clk(clk), .rst_n(rst_n), .restart(kfall), .expired(idle_to));

   // frame sequencer
   rx_step_t          step;
   logic [CNT_W-1:0]  bit_idx;
   logic [DATA_W-1:0] shreg;
   logic              par_exp;

   always_comb par_exp = odd_par_bit(64'(shreg), DATA_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step       <= ST_IDLE;
         bit_idx    <= '0;
         shreg      <= '0;
         rx_byte    <= '0;
         rx_valid   <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         rx_valid   <= 1'b0;
         parity_err <= 1'b0;
         if (kfall) begin
            unique case (step)
               ST_IDLE: begin
                  if (!kdat_s) begin
                     step    <= ST_DATA;
                     bit_idx <= '0;
                  end
               end
               ST_DATA: begin
                  shreg   <= {kdat_s, shreg[DATA_W-1:1]};
                  bit_idx <= bit_idx + 1'b1;
                  if (bit_idx == LAST_BIT) step <= ST_PAR;
               end
               ST_PAR: begin
                  if (kdat_s == par_exp) begin
                     step <= ST_STOP;
                  end else begin
                     step       <= ST_IDLE;
                     parity_err <= 1'b1;
                  end
               end
               ST_STOP: begin
                  step <= ST_IDLE;
                  if (kdat_s) begin
                     rx_byte  <= shreg;
                     rx_valid <= 1'b1;
                  end
               end
            endcase
         end else if (idle_to) begin
            step <= ST_IDLE;
         end
      end
   end

   // assertions
   assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_err_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |=> !parity_err);

   assert_err_to_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |-> step == ST_IDLE);

   assert_timeout_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_to && !kfall) |=> step == ST_IDLE);

   assert_byte_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_byte));

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && parity_err));

   assert_valid_from_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(step) == ST_STOP);

endmodule

// File: tb/test_ps2_frame_rx.sv
`timescale 1ns/1ps
module test_ps2_frame_rx;

   localparam int unsigned DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          kclk = 1'b1;
   logic          kdat = 1'b1;
   logic [DW-1:0] rx_byte;
   logic          rx_valid;
   logic          parity_err;

   int checks = 0;
   int fails  = 0;
   int n_valid = 0;
   int n_err   = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   // 1 MHz nominal with 100 us gives a 100-cycle timeout
   ps2_frame_rx #(
      .DATA_W(DW), .SYNC_STAGES(2), .CLK_FREQ_HZ(1_000_000), .TIMEOUT_US(100)
   ) i_ps2_frame_rx (
      .clk(clk), .rst_n(rst_n), .ps2_clk_in(kclk), .ps2_dat_in(kdat),
      .rx_byte(rx_byte), .rx_valid(rx_valid), .parity_err(parity_err));

   // pulse counters, sampled away from the active edge
   always @(negedge clk) begin
      if (rst_n && rx_valid)   n_valid++;
      if (rst_n && parity_err) n_err++;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send_bit(input logic b, input int gap = 10);
      @(negedge clk);
      kdat = b;
      repeat (5) @(negedge clk);
      kclk = 1'b0;
      repeat (15) @(negedge clk);
      kclk = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   function automatic logic good_par(input logic [DW-1:0] d);
      return ~^d;
   endfunction

   task automatic send_frame(input logic [DW-1:0] d, input logic flip_par,
                             input logic start_b, input logic stop_b);
      send_bit(start_b);
      for (int i = 0; i < DW; i++) send_bit(d[i]);
      send_bit(good_par(d) ^ flip_par);
      send_bit(stop_b);
      repeat (20) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R1", "rx_valid in reset", int'(rx_valid), 0);
      chk("R1", "parity_err in reset", int'(parity_err), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rx_byte after reset", int'(rx_byte), 0);
      chk("R1", "rx_valid after reset", int'(rx_valid), 0);
   endtask

   task automatic t_good(input logic [DW-1:0] d);
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      send_frame(d, 1'b0, 1'b0, 1'b1);
      chk("R2", "valid cycles", n_valid - v0, 1);
      chk("R2", "byte", int'(rx_byte), int'(d));
      chk("R3", "no parity error on good frame", n_err - e0, 0);
   endtask

   task automatic t_bad_parity(input logic [DW-1:0] d);
      int v0, e0;
      logic [DW-1:0] held;
      v0 = n_valid; e0 = n_err; held = rx_byte;
      send_frame(d, 1'b1, 1'b0, 1'b1);
      chk("R3", "parity_err cycles", n_err - e0, 1);
      chk("R3", "no valid on bad parity", n_valid - v0, 0);
      chk("R7", "byte held after bad parity", int'(rx_byte), int'(held));
   endtask

   task automatic t_start_high();
      int v0, e0;
      v0 = n_valid; e0 = n_err;
      send_bit(1'b1);
      send_bit(1'b1);
      repeat (10) @(negedge clk);
      chk("R4", "no valid on high start", n_valid - v0, 0);
      chk("R4", "no error on high start", n_err - e0, 0);
      t_good(8'h77);
   endtask

   task automatic t_stop_low();
      int v0, e0;
      logic [DW-1:0] held;
      v0 = n_valid; e0 = n_err; held = rx_byte;
      send_frame(8'h42, 1'b0, 1'b0, 1'b0);
      chk("R5", "no valid on low stop", n_valid - v0, 0);
      chk("R5", "no error on low stop", n_err - e0, 0);
      chk("R7", "byte held after low stop", int'(rx_byte), int'(held));
      t_good(8'h3C);
   endtask

   task automatic t_timeout();
      int v0;
      // start bit and three data bits, then a stall well past the timeout
      send_bit(1'b0);
      send_bit(1'b1);
      send_bit(1'b0);
      send_bit(1'b1, 200);
      v0 = n_valid;
      send_frame(8'h5A, 1'b0, 1'b0, 1'b1);
      chk("R6", "valid after abandoned frame", n_valid - v0, 1);
      chk("R6", "byte after abandoned frame", int'(rx_byte), 'h5A);
   endtask

   task automatic t_slow_bits(input logic [DW-1:0] d);
      int v0;
      logic [DW-1:0] bits;
      v0 = n_valid; bits = d;
      // 60-cycle gaps keep each fall-to-fall spacing near 80, under the 100 limit
      send_bit(1'b0, 60);
      for (int i = 0; i < DW; i++) send_bit(bits[i], 60);
      send_bit(good_par(d), 60);
      send_bit(1'b1, 20);
      chk("R6", "valid with slow bits", n_valid - v0, 1);
      chk("R6", "byte with slow bits", int'(rx_byte), int'(d));
   endtask

   initial begin
      t_reset();
      repeat (10) @(negedge clk);
      t_good(8'h00);
      t_good(8'hFF);
      t_good(8'hA5);
      t_good(8'h01);
      t_good(8'h80);
      t_good(8'h1C);
      t_bad_parity(8'h3C);
      t_bad_parity(8'h07);
      t_start_high();
      t_stop_low();
      t_timeout();
      t_slow_bits(8'hC3);
      chk("R8", "rx_byte final", int'(rx_byte), 'hC3);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired before all scenarios completed");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule